// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is a single-lane SPI master that software drives through a small 32-bit register window. Software programs a serial clock divider, the clock polarity and phase, the bit order, which chip-select line is used, the idle level of every chip-select line, and how chip select behaves around frames. It then writes bytes into a transmit queue and collects received bytes from a receive queue. The full and empty state of each queue shows in bit 31 of the matching data register.

Each byte taken from the transmit queue becomes one 8-bit frame on the wire. The byte clocked in during that frame goes into the receive queue. A frame starts only once the previous one has finished, and the serial clock rests at the polarity level between frames. The register bus has no wait states: a read returns its data in the same cycle, a write lands on the next clock edge, and a read of the receive data register removes the oldest byte.

Top module: `spi_host_ctl`

## Requirements
- R1: After reset, the following hold. The divider reads 3. The idle-level register (offset 0x14) reads all ones, one bit for each chip-select line. The format register (0x40) reads 0x00080000. The enable flag at 0x60 reads 1. Every chip-select output is high and the serial clock is low. The receive data register reads 0x80000000 (empty), and the transmit data register reads 0 (not full).
- R2: The divider register (0x00) keeps bits 11:0 of a write. Each serial clock half-period lasts divider+1 input clock cycles, so a frame takes 16*(divider+1) cycles.
- R3: In the clock-mode register (0x04), bit 0 selects phase and bit 1 selects polarity. With phase 0, data is sampled on the leading edge of each bit. With phase 1, data is sampled on the trailing edge. Between frames the serial clock sits at the polarity value.
- R4: In the format register (0x40), bit 2 set sends and receives least significant bit first, and clear sends most significant bit first. Bits 1:0, bit 3 and bits 19:16 read back what was written, but frames are always single-lane and 8 bits long.
- R5: A write to 0x48 queues bits 7:0 in an 8-entry transmit queue. Reading 0x48 returns bit 31 set while the queue is full. A write while the queue is full is dropped and sends no frame.
- R6: Reading 0x4C returns 0x80000000 when the receive queue is empty. Otherwise it returns the oldest received byte in bits 7:0 with bit 31 clear, and removes that byte.
- R7: Every completed frame offers its received byte to the 8-entry receive queue. When the queue is full, the new byte is discarded and the stored bytes are kept in order.
- R8: Chip-select mode register (0x18), value 0 (auto, and any value other than 2 or 3): the selected line is asserted for each frame and returns to its idle level when that frame ends.
- R9: Chip-select mode value 2 (hold): the selected line stays asserted after a frame ends. It returns to its idle level when 0x10, 0x14 or 0x18 is written while no frame is in progress.
- R10: Chip-select mode value 3 (off): transfers leave every chip-select line at its idle level.
- R11: Each chip-select line rests at its bit in 0x14. The line whose index equals the value in 0x10 is asserted by driving it to the inverse of that bit. A selection index with no matching line asserts no line.
- R12: Reads of offsets that have no register (for example 0x08 and 0x7C) return 0. Queued bytes go out one whole frame after another, with no overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busValid | input | 1 | Register access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle |
| sclkOut | output | 1 | Serial clock |
| mosiOut | output | 1 | Serial data to the device |
| misoIn | input | 1 | Serial data from the device |
| csN | output | 4 | Chip-select lines |

## Verification
The bench builds the block with its defaults: four chip-select lines, 8-entry queues, a 12-bit divider and a reset divider of 3. Four lines leave room for an out-of-range selection index (5) and for idle-level patterns that mix high and low lines. With a divider of 0, one frame is short enough that nine bytes can be written back to back before the first frame ends, which makes both a full transmit queue and a receive overflow reachable. A device model in the bench follows the programmed phase and polarity and checks the bit order in both directions for all four clock modes.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

  localparam logic [7:0] ADR_DIV    = 8'h00;
  localparam logic [7:0] ADR_CKMODE = 8'h04;
  localparam logic [7:0] ADR_CSSEL  = 8'h10;
  localparam logic [7:0] ADR_CSIDLE = 8'h14;
  localparam logic [7:0] ADR_CSMODE = 8'h18;
  localparam logic [7:0] ADR_FMT    = 8'h40;
  localparam logic [7:0] ADR_TX     = 8'h48;
  localparam logic [7:0] ADR_RX     = 8'h4C;
  localparam logic [7:0] ADR_FLASH  = 8'h60;

  localparam logic [1:0] CSM_AUTO = 2'd0;
  localparam logic [1:0] CSM_HOLD = 2'd2;
  localparam logic [1:0] CSM_OFF  = 2'd3;

  typedef struct packed {
    logic startFrame;   // take head of TX queue, load shifter
    logic leadEdge;     // serial clock leaves its idle level
    logic trailEdge;    // serial clock returns to its idle level
    logic finishFrame;  // offer received byte to RX queue
  } spiStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SHIFT  = 2'd1,
    ST_FINISH = 2'd2
  } spiState_e;

endpackage

// File: rtl/spi_ctl_fifo.sv
module spi_ctl_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = store[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= wdata;
  end

endmodule

// File: rtl/spi_ctl_control.sv
module spi_ctl_control
  import spi_ctl_pkg::*;
#(
  parameter int DIV_W      = 12,
  parameter int FRAME_BITS = 8,
  localparam int EDGES     = 2 * FRAME_BITS,
  localparam int EDGE_W    = $clog2(EDGES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txEmpty,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       csMode,
  input  logic             csRelease,
  output spiStrobe_t       strobe,
  output logic             sckPhase,
  output logic             csActive,
  output logic             busy
);

  spiState_e         state;
  logic [DIV_W-1:0]  halfCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic              edgeNow;

  assign busy    = (state != ST_IDLE);
  assign edgeNow = (state == ST_SHIFT) && (halfCnt == '0);

  always_comb begin
    strobe             = '0;
    strobe.startFrame  = (state == ST_IDLE) && !txEmpty;
    strobe.leadEdge    = edgeNow && !edgeCnt[0];
    strobe.trailEdge   = edgeNow && edgeCnt[0];
    strobe.finishFrame = (state == ST_FINISH);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      halfCnt  <= '0;
      edgeCnt  <= '0;
      sckPhase <= 1'b0;
      csActive <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (strobe.startFrame) begin
            state    <= ST_SHIFT;
            halfCnt  <= divisor;
            edgeCnt  <= '0;
            csActive <= (csMode != CSM_OFF);
          end else if (csRelease) begin
            csActive <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (edgeNow) begin
            halfCnt  <= divisor;
            sckPhase <= ~sckPhase;
            edgeCnt  <= edgeCnt + 1'b1;
            if (edgeCnt == EDGE_W'(EDGES - 1)) state <= ST_FINISH;
          end else begin
            halfCnt <= halfCnt - 1'b1;
          end
        end
        ST_FINISH: begin
          state <= ST_IDLE;
          if (csMode != CSM_HOLD) csActive <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_ctl_datapath.sv
module spi_ctl_datapath
  import spi_ctl_pkg::*;
#(
  parameter int NUM_CS     = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 12,
  parameter int DIV_RESET  = 3,
  parameter int FRAME_BITS = 8,
  localparam int SEL_W     = 8,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [7:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              misoIn,
  output logic              mosiOut,
  output logic              sclkOut,
  output logic [NUM_CS-1:0] csN,
  input  spiStrobe_t        strobe,
  input  logic              sckPhase,
  input  logic              csActive,
  output logic              txEmpty,
  output logic [DIV_W-1:0]  divisor,
  output logic [1:0]        csMode,
  output logic              csRelease,
  output logic [NUM_CS-1:0] csIdleLvl,
  output logic              pol,
  output logic              txFull,
  output logic              txWrite,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount
);

  logic [1:0]            ckMode;
  logic [SEL_W-1:0]      csSel;
  logic [1:0]            protoReg;
  logic                  lsbFirst, dirReg, flashEn;
  logic [3:0]            lenReg;
  logic [FRAME_BITS-1:0] txHead, rxHead, txShift, rxShift, txOrdered, rxOrdered;
  logic                  rxFull, rxEmpty, rxPop, isRd, isWr, cpha;
  logic                  shiftEdge, sampleEdge;

  function automatic logic [FRAME_BITS-1:0] revBits(input logic [FRAME_BITS-1:0] v);
    logic [FRAME_BITS-1:0] r;
    for (int i = 0; i < FRAME_BITS; i++) r[i] = v[FRAME_BITS-1-i];
    return r;
  endfunction

  assign isRd      = busValid && !busWrite;
  assign isWr      = busValid && busWrite;
  assign txWrite   = isWr && (busAddr == ADR_TX);
  assign rxPop     = isRd && (busAddr == ADR_RX);
  assign csRelease = isWr && ((busAddr == ADR_CSSEL) || (busAddr == ADR_CSIDLE) ||
                              (busAddr == ADR_CSMODE));
  assign pol       = ckMode[1];
  assign cpha      = ckMode[0];

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divisor   <= DIV_W'(DIV_RESET);
      ckMode    <= '0;
      csSel     <= '0;
      csIdleLvl <= '1;
      csMode    <= CSM_AUTO;
      protoReg  <= '0;
      lsbFirst  <= 1'b0;
      dirReg    <= 1'b0;
      lenReg    <= 4'd8;
      flashEn   <= 1'b1;
    end else if (isWr) begin
      case (busAddr)
        ADR_DIV:    divisor   <= busWdata[DIV_W-1:0];
        ADR_CKMODE: ckMode    <= busWdata[1:0];
        ADR_CSSEL:  csSel     <= busWdata[SEL_W-1:0];
        ADR_CSIDLE: csIdleLvl <= busWdata[NUM_CS-1:0];
        ADR_CSMODE: csMode    <= busWdata[1:0];
        ADR_FMT: begin
          protoReg <= busWdata[1:0];
          lsbFirst <= busWdata[2];
          dirReg   <= busWdata[3];
          lenReg   <= busWdata[19:16];
        end
        ADR_FLASH:  flashEn   <= busWdata[0];
        default: ;
      endcase
    end
  end

  // read mux, same-cycle
  always_comb begin
    busRdata = '0;
    if (isRd) begin
      case (busAddr)
        ADR_DIV:    busRdata = 32'(divisor);
        ADR_CKMODE: busRdata = {30'b0, ckMode};
        ADR_CSSEL:  busRdata = 32'(csSel);
        ADR_CSIDLE: busRdata = 32'(csIdleLvl);
        ADR_CSMODE: busRdata = {30'b0, csMode};
        ADR_FMT:    busRdata = {12'b0, lenReg, 12'b0, dirReg, lsbFirst, protoReg};
        ADR_TX:     busRdata = {txFull, 31'b0};
        ADR_RX:     busRdata = rxEmpty ? 32'h8000_0000 : 32'(rxHead);
        ADR_FLASH:  busRdata = {31'b0, flashEn};
        default:    busRdata = '0;
      endcase
    end
  end

  spi_ctl_fifo #(.WIDTH(FRAME_BITS), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rstN(rstN), .push(txWrite), .wdata(busWdata[FRAME_BITS-1:0]),
    .pop(strobe.startFrame), .head(txHead), .count(txCount), .full(txFull),
    .empty(txEmpty)
  );

  assign rxOrdered = lsbFirst ? revBits(rxShift) : rxShift;

  spi_ctl_fifo #(.WIDTH(FRAME_BITS), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rstN(rstN), .push(strobe.finishFrame), .wdata(rxOrdered),
    .pop(rxPop), .head(rxHead), .count(rxCount), .full(rxFull), .empty(rxEmpty)
  );

  // serial shifters
  assign txOrdered  = lsbFirst ? revBits(txHead) : txHead;
  assign shiftEdge  = cpha ? strobe.leadEdge : strobe.trailEdge;
  assign sampleEdge = cpha ? strobe.trailEdge : strobe.leadEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      mosiOut <= 1'b0;
    end else begin
      if (strobe.startFrame) begin
        if (!cpha) begin
          mosiOut <= txOrdered[FRAME_BITS-1];
          txShift <= {txOrdered[FRAME_BITS-2:0], 1'b0};
        end else begin
          txShift <= txOrdered;
        end
      end else if (shiftEdge) begin
        mosiOut <= txShift[FRAME_BITS-1];
        txShift <= {txShift[FRAME_BITS-2:0], 1'b0};
      end
      if (sampleEdge) rxShift <= {rxShift[FRAME_BITS-2:0], misoIn};
    end
  end

  assign sclkOut = pol ^ sckPhase;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign csN[i] = csIdleLvl[i] ^ (csActive && (csSel == SEL_W'(i)));
  end

endmodule

// File: rtl/spi_host_ctl.sv
module spi_host_ctl
  import spi_ctl_pkg::*;
#(
  parameter int NUM_CS     = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 12,
  parameter int DIV_RESET  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [7:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              sclkOut,
  output logic              mosiOut,
  input  logic              misoIn,
  output logic [NUM_CS-1:0] csN
);

  localparam int FRAME_BITS = 8;
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);

  spiStrobe_t        strobe;
  logic              sckPhase, csActive, busy, txEmpty, csRelease, pol;
  logic              txFull, txWrite;
  logic [DIV_W-1:0]  divisor;
  logic [1:0]        csModeCur;
  logic [NUM_CS-1:0] csIdleLvl;
  logic [CNT_W-1:0]  txCount, rxCount;

  spi_ctl_control #(.DIV_W(DIV_W), .FRAME_BITS(FRAME_BITS)) u_ctl (
    .clk(clk), .rstN(rstN), .txEmpty(txEmpty), .divisor(divisor),
    .csMode(csModeCur), .csRelease(csRelease), .strobe(strobe),
    .sckPhase(sckPhase), .csActive(csActive), .busy(busy)
  );

  spi_ctl_datapath #(
    .NUM_CS(NUM_CS), .FIFO_DEPTH(FIFO_DEPTH), .DIV_W(DIV_W),
    .DIV_RESET(DIV_RESET), .FRAME_BITS(FRAME_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .misoIn(misoIn), .mosiOut(mosiOut), .sclkOut(sclkOut), .csN(csN),
    .strobe(strobe), .sckPhase(sckPhase), .csActive(csActive),
    .txEmpty(txEmpty), .divisor(divisor), .csMode(csModeCur),
    .csRelease(csRelease), .csIdleLvl(csIdleLvl), .pol(pol),
    .txFull(txFull), .txWrite(txWrite), .txCount(txCount), .rxCount(rxCount)
  );

endmodule

// File: rtl/spi_host_ctl_checks.sv
module spi_host_ctl_checks #(
  parameter int NUM_CS     = 4,
  parameter int FIFO_DEPTH = 8,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CS-1:0] csN,
  input logic [NUM_CS-1:0] csIdleLvl,
  input logic [1:0]        csModeCur,
  input logic              sclkOut,
  input logic              pol,
  input logic              busy,
  input logic              txFull,
  input logic              txWrite,
  input logic              startFrame,
  input logic [CNT_W-1:0]  txCount,
  input logic [CNT_W-1:0]  rxCount
);

  // R11: at most one line away from its idle level
  p_one_line_r11: assert property (@(posedge clk) disable iff (!rstN)
    $countones(csN ^ csIdleLvl) <= 1);

  // R10: off mode keeps every line at idle between frames
  p_off_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && csModeCur == 2'd3 && $past(!busy)) |-> (csN == csIdleLvl));

  // R3: clock rests at polarity level when no frame runs
  p_sclk_rest_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sclkOut == pol));

  // R5: a write into a full queue leaves its occupancy unchanged
  p_tx_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (txFull && txWrite && !startFrame) |=> (txCount == $past(txCount)));

  // R7: receive queue never exceeds its depth
  p_rx_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= CNT_W'(FIFO_DEPTH));

  // R12: a frame begins only with a queued byte
  p_start_needs_data_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(txCount) != '0));

endmodule

bind spi_host_ctl spi_host_ctl_checks #(.NUM_CS(NUM_CS), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .csIdleLvl(csIdleLvl), .csModeCur(csModeCur),
  .sclkOut(sclkOut), .pol(pol), .busy(busy), .txFull(txFull), .txWrite(txWrite),
  .startFrame(strobe.startFrame), .txCount(txCount), .rxCount(rxCount)
);

// File: tb/spi_host_ctl_tb.sv
`timescale 1ns/1ps
module spi_host_ctl_tb;

  localparam logic [7:0] A_DIV = 8'h00, A_CKM = 8'h04, A_SEL = 8'h10, A_IDLE = 8'h14,
                         A_CSM = 8'h18, A_FMT = 8'h40, A_TX = 8'h48, A_RX = 8'h4C,
                         A_FLASH = 8'h60;
  localparam logic [31:0] EMPTY = 32'h8000_0000;

  // {mode[1:0], lsbFirst, div[11:0], hostByte[7:0], deviceByte[7:0]}
  localparam int NVEC = 8;
  localparam logic [30:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 12'd0, 8'hA5, 8'h3C},
    {2'd1, 1'b0, 12'd1, 8'h5A, 8'hC3},
    {2'd2, 1'b0, 12'd2, 8'hF0, 8'h0F},
    {2'd3, 1'b0, 12'd0, 8'h81, 8'h7E},
    {2'd0, 1'b1, 12'd1, 8'h12, 8'h48},
    {2'd1, 1'b1, 12'd0, 8'hC4, 8'h21},
    {2'd2, 1'b1, 12'd3, 8'h39, 8'h9C},
    {2'd3, 1'b1, 12'd2, 8'hE7, 8'h5B}
  };

  logic clk = 0, rstN = 0;
  logic busValid = 0, busWrite = 0;
  logic [7:0] busAddr = 0;
  logic [31:0] busWdata = 0, busRdata;
  logic sclkOut, mosiOut, misoIn;
  logic [3:0] csN;

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;

  // device model
  logic misoMdl = 0, loopBack = 0, slvOn = 0, polB = 0, cphaB = 0;
  logic [7:0] slvTx = 0, slvRx = 0;
  int edgeCount = 0;
  int edgeCyc [16];

  assign misoIn = loopBack ? mosiOut : misoMdl;

  spi_host_ctl u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .sclkOut(sclkOut), .mosiOut(mosiOut), .misoIn(misoIn), .csN(csN)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  always @(sclkOut) begin
    if (slvOn) begin
      if (edgeCount < 16) edgeCyc[edgeCount] = cyc;
      edgeCount++;
      if ((sclkOut != polB) ^ cphaB) slvRx = {slvRx[6:0], mosiOut};
      else begin
        misoMdl = slvTx[7];
        slvTx = {slvTx[6:0], 1'b0};
      end
    end
  end

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busValid = 0; busWrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    @(posedge clk); #1;
    busValid = 0;
  endtask

  task automatic waitRx(output logic [31:0] d);
    d = EMPTY;
    for (int n = 0; n < 3000 && d[31]; n++) rd(A_RX, d);
  endtask

  task automatic drainRx();
    logic [31:0] d;
    for (int n = 0; n < 20; n++) rd(A_RX, d);
  endtask

  task automatic prepSlave(input logic [7:0] b, input logic cpha);
    slvTx = b; slvRx = 0; edgeCount = 0;
    if (!cpha) begin
      misoMdl = b[7];
      slvTx = {b[6:0], 1'b0};
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    cycles(3);
    rstN = 1;
    cycles(2);

    // R1 reset state
    chk("R1 csN", 32'(csN), 32'hF);
    chk("R1 sclk", 32'(sclkOut), 0);
    rd(A_DIV, d);   chk("R1 div", d, 3);
    rd(A_IDLE, d);  chk("R1 idle", d, 32'hF);
    rd(A_FMT, d);   chk("R1 fmt", d, 32'h0008_0000);
    rd(A_FLASH, d); chk("R1 flash", d, 1);
    rd(A_RX, d);    chk("R1 rx empty", d, EMPTY);
    rd(A_TX, d);    chk("R1 tx", d, 0);

    // R12 unmapped offsets
    rd(8'h08, d); chk("R12 unmapped 08", d, 0);
    rd(8'h7C, d); chk("R12 unmapped 7C", d, 0);

    // R2 divider width
    wr(A_DIV, 32'h0000_F005);
    rd(A_DIV, d); chk("R2 div mask", d, 32'h005);

    // R4 format readback
    wr(A_FMT, 32'h0008_000B);
    rd(A_FMT, d); chk("R4 fmt readback", d, 32'h0008_000B);

    // R3 R4 R6 vector table across modes and bit orders
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] md; logic lsb; logic [11:0] dv; logic [7:0] hb, sb;
      {md, lsb, dv, hb, sb} = VEC[v];
      wr(A_CKM, 32'(md));
      wr(A_FMT, 32'h0008_0000 | (32'(lsb) << 2));
      wr(A_DIV, 32'(dv));
      polB = md[1]; cphaB = md[0];
      prepSlave(sb, md[0]);
      slvOn = 1;
      wr(A_TX, 32'(hb));
      waitRx(d);
      slvOn = 0;
      chk($sformatf("R6 R4 vec%0d host byte", v), d, 32'(lsb ? rev8(sb) : sb));
      chk($sformatf("R3 R4 vec%0d wire byte", v), 32'(slvRx), 32'(lsb ? rev8(hb) : hb));
      chk($sformatf("R3 vec%0d sclk rest", v), 32'(sclkOut), 32'(md[1]));
    end

    // R2 half-period timing with divider 5
    wr(A_CKM, 0); wr(A_FMT, 32'h0008_0000); wr(A_DIV, 5);
    polB = 0; cphaB = 0; prepSlave(8'h00, 0); slvOn = 1;
    wr(A_TX, 32'h55);
    waitRx(d); slvOn = 0;
    chk("R2 half period", 32'(edgeCyc[1] - edgeCyc[0]), 6);
    chk("R2 frame edges", 32'(edgeCount), 16);

    // R8 auto mode
    wr(A_DIV, 3); wr(A_CSM, 0); wr(A_SEL, 2);
    wr(A_TX, 32'h11);
    cycles(10); chk("R8 auto during", 32'(csN), 32'hB);
    cycles(100); chk("R8 auto after", 32'(csN), 32'hF);

    // R9 hold mode, released by mode write then by select write
    wr(A_CSM, 2);
    wr(A_TX, 32'h22);
    cycles(110); chk("R9 hold after frame", 32'(csN), 32'hB);
    wr(A_CSM, 2); chk("R9 release by mode write", 32'(csN), 32'hF);
    wr(A_TX, 32'h23);
    cycles(110); chk("R9 hold again", 32'(csN), 32'hB);
    wr(A_SEL, 2); chk("R9 release by select write", 32'(csN), 32'hF);

    // R10 off mode
    wr(A_CSM, 3);
    wr(A_TX, 32'h33);
    cycles(10); chk("R10 off during", 32'(csN), 32'hF);
    cycles(100);

    // R11 idle levels and selection
    wr(A_IDLE, 32'hA); wr(A_CSM, 0); wr(A_SEL, 0);
    chk("R11 idle pattern", 32'(csN), 32'hA);
    wr(A_TX, 32'h44);
    cycles(10); chk("R11 line0 inverted", 32'(csN), 32'hB);
    cycles(100);
    wr(A_SEL, 5);
    wr(A_TX, 32'h45);
    cycles(10); chk("R11 out of range", 32'(csN), 32'hA);
    cycles(100);
    wr(A_IDLE, 32'hF);

    // R5 R7 R12 queue limits with loopback and divider 0
    drainRx();
    wr(A_CSM, 3); wr(A_DIV, 0); wr(A_CKM, 0);
    loopBack = 1; polB = 0; cphaB = 0; edgeCount = 0; slvOn = 1;
    for (int i = 0; i < 9; i++) wr(A_TX, 32'h10 + 32'(i));
    rd(A_TX, d); chk("R5 tx full flag", d, EMPTY);
    wr(A_TX, 32'hEE);
    cycles(400);
    chk("R5 R12 frames sent", 32'(edgeCount), 144);
    for (int i = 0; i < 8; i++) begin
      rd(A_RX, d);
      chk($sformatf("R7 rx order %0d", i), d, 32'h10 + 32'(i));
    end
    rd(A_RX, d); chk("R7 overflow discarded", d, EMPTY);
    slvOn = 0; loopBack = 0;

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule